// File: doc/BRIEF.md
# Branch and Indexed Address Generator

This block forms the addresses a small 8-bit accumulator-based controller core needs whenever control flow or a code-space table read leaves plain sequential fetch. The fetch stage presents the address and byte length of the current instruction, its opcode and up to two operand bytes, the accumulator and the 16-bit data pointer. From these the block decodes which addressing form the opcode uses. It then returns the sequential successor address, the branch target and the code-memory read address for table lookups.

Every address is relative to the successor PC (instruction address plus length), never to the instruction's own address. A branch-taken strobe from the condition logic selects whether the registered PC loads the target or the successor. An extra requested-target input lets assembler-side logic ask whether an absolute destination can be encoded in the 11-bit in-page form from this position.

Top module: `brx_addr_gen`

## Requirements
- R1: `seq_pc` equals `instr_addr + instr_len` modulo 65536.
- R2: Relative branches take the signed last operand byte (operand 2 when `instr_len` is 3, operand 1 otherwise), sign-extend it and add it to `seq_pc` modulo 65536. The relative opcodes are 80h (unconditional), 10h, 20h, 30h, 40h, 50h, 60h, 70h, D5h, D8h–DFh and B4h–BFh.
- R3: An opcode whose low five bits are 00001 (in-page jump) or 10001 (in-page call) targets `{seq_pc[15:11], opc[7:5], opr1}`.
- R4: Opcodes 02h (long jump) and 12h (long call) target `{opr1, opr2}`.
- R5: Opcode 73h (indirect jump) targets `ptr_base + acc` modulo 65536, with the accumulator zero-extended.
- R6: Opcode 93h raises `code_rd_en` and sets `code_rd_addr` to `ptr_base + acc` modulo 65536.
- R7: Opcode 83h raises `code_rd_en` and sets `code_rd_addr` to `seq_pc + acc` modulo 65536.
- R8: Any other opcode (for example 00h, B0h, E5h) leaves `is_jump` and `code_rd_en` low and drives `jump_tgt` and `code_rd_addr` with `seq_pc`. `is_jump` and `code_rd_en` are never high together.
- R9: `page_miss` is high exactly when `want_addr[15:11]` differs from `seq_pc[15:11]`.
- R10: `pc_q` is 0000h during reset. At each clock edge it loads `jump_tgt` when `take` is high and `seq_pc` otherwise.
- R11: `op_class` encodes the decoded form as 0 none, 1 relative, 2 in-page jump, 3 in-page call, 4 long, 5 indirect jump, 6 table via pointer, 7 table via PC. `is_jump` is high exactly for classes 1 to 5.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| instr_addr | input | 16 | Address of the current instruction |
| instr_len | input | 2 | Instruction length in bytes (1 to 3) |
| opc | input | 8 | Opcode byte |
| opr1 | input | 8 | First operand byte |
| opr2 | input | 8 | Second operand byte |
| acc | input | 8 | Accumulator |
| ptr_base | input | 16 | Data pointer |
| want_addr | input | 16 | Requested absolute target for the page reach check |
| take | input | 1 | Branch-taken strobe |
| seq_pc | output | 16 | Successor instruction address |
| jump_tgt | output | 16 | Computed branch target |
| is_jump | output | 1 | Opcode is a PC-changing form |
| code_rd_addr | output | 16 | Code-memory table read address |
| code_rd_en | output | 1 | Table read requested |
| page_miss | output | 1 | Requested target outside the successor's 2K page |
| op_class | output | 3 | Decoded addressing form |
| pc_q | output | 16 | Registered program counter |

## Verification
The bench aims at the successor-versus-own-address distinction. A design that used the instruction address would send an in-page call at 3FFEh into page 3800h, and would read a PC-indexed table one byte (or one length) too low. It drives a 2-byte relative loop onto itself with offset FEh and the extreme offsets 7Fh and 80h, where a zero-extending adder lands 256 bytes off. It also checks 3-byte relative forms, which a design reading the wrong operand byte would send to a wrong target. Wrap cases (data pointer FFFFh plus accumulator, successor past FFFFh) and decode neighbours such as B0h–B3h, which must not be taken as relative, close the list. These run beside a long stream of random opcodes compared against a behavioural model every cycle.

// File: rtl/brx_pkg.sv
package brx_pkg;

   localparam int LEN_W = 2;

   typedef enum logic [2:0] {
      CLS_NONE = 3'd0,
      CLS_REL  = 3'd1,
      CLS_PGJ  = 3'd2,
      CLS_PGC  = 3'd3,
      CLS_FAR  = 3'd4,
      CLS_IDXJ = 3'd5,
      CLS_TBLP = 3'd6,
      CLS_TBLC = 3'd7
   } brx_cls_e;

   localparam logic [7:0] OP_SHORT  = 8'h80;
   localparam logic [7:0] OP_FARJ   = 8'h02;
   localparam logic [7:0] OP_FARC   = 8'h12;
   localparam logic [7:0] OP_IDXJ   = 8'h73;
   localparam logic [7:0] OP_TBLP   = 8'h93;
   localparam logic [7:0] OP_TBLC   = 8'h83;
   localparam logic [4:0] PG_JMP_LO = 5'b00001;
   localparam logic [4:0] PG_CAL_LO = 5'b10001;

endpackage

// File: rtl/brx_decode.sv
module brx_decode
   import brx_pkg::*;
#(
   parameter int DW       = 8,
   parameter bit COND_REL = 1'b1
) (
   input  logic [DW-1:0] opc,
   output brx_cls_e      cls
);

   logic cond_hit;

   generate
      if (COND_REL) begin : g_cond
         logic flag_br, cnt_dir, cnt_reg, cmp_br;
         always_comb begin
            flag_br = (opc == 8'h40) || (opc == 8'h50) ||
                      (opc == 8'h60) || (opc == 8'h70);
            cnt_dir = (opc == 8'hD5) || (opc == 8'h10) ||
                      (opc == 8'h20) || (opc == 8'h30);
            cnt_reg = (opc[7:3] == 5'b11011);
            cmp_br  = (opc[7:4] == 4'hB) && (opc[3:2] != 2'b00);
            cond_hit = flag_br || cnt_dir || cnt_reg || cmp_br;
         end
      end else begin : g_nocond
         assign cond_hit = 1'b0;
      end
   endgenerate

   always_comb begin
      cls = CLS_NONE;
      if (opc[4:0] == PG_JMP_LO) begin
         cls = CLS_PGJ;
      end else if (opc[4:0] == PG_CAL_LO) begin
         cls = CLS_PGC;
      end else begin
         unique case (opc)
            OP_SHORT:         cls = CLS_REL;
            OP_FARJ, OP_FARC: cls = CLS_FAR;
            OP_IDXJ:          cls = CLS_IDXJ;
            OP_TBLP:          cls = CLS_TBLP;
            OP_TBLC:          cls = CLS_TBLC;
            default:          cls = cond_hit ? CLS_REL : CLS_NONE;
         endcase
      end
   end

endmodule

// File: rtl/brx_target.sv
module brx_target
   import brx_pkg::*;
#(
   parameter int AW         = 16,
   parameter int DW         = 8,
   parameter int PAGE_W     = 11,
   parameter bit SHARED_ADD = 1'b1
) (
   input  brx_cls_e         cls,
   input  logic [AW-1:0]    instr_addr,
   input  logic [LEN_W-1:0] instr_len,
   input  logic [DW-1:0]    opc,
   input  logic [DW-1:0]    opr1,
   input  logic [DW-1:0]    opr2,
   input  logic [DW-1:0]    acc,
   input  logic [AW-1:0]    ptr_base,
   input  logic [AW-1:0]    want_addr,
   output logic [AW-1:0]    seq_pc,
   output logic [AW-1:0]    jump_tgt,
   output logic [AW-1:0]    code_rd_addr,
   output logic             code_rd_en,
   output logic             page_miss
);

   localparam int HI_W  = AW - PAGE_W;
   localparam int SEL_W = PAGE_W - DW;

   logic [DW-1:0] rel_off;
   logic [AW-1:0] acc_ext, rel_tgt, page_tgt, far_tgt;
   logic [AW-1:0] ptr_sum, pc_sum;

   assign seq_pc   = instr_addr + AW'(instr_len);
   assign rel_off  = (instr_len == LEN_W'(3)) ? opr2 : opr1;
   assign rel_tgt  = seq_pc + {{(AW-DW){rel_off[DW-1]}}, rel_off};
   assign page_tgt = {seq_pc[AW-1 -: HI_W], opc[DW-1 -: SEL_W], opr1};
   assign far_tgt  = {opr1, opr2};
   assign acc_ext  = {{(AW-DW){1'b0}}, acc};

   generate
      if (SHARED_ADD) begin : g_shared
         logic [AW-1:0] idx_base, idx_sum;
         assign idx_base = (cls == CLS_TBLC) ? seq_pc : ptr_base;
         assign idx_sum  = idx_base + acc_ext;
         assign ptr_sum  = idx_sum;
         assign pc_sum   = idx_sum;
      end else begin : g_split
         assign ptr_sum = ptr_base + acc_ext;
         assign pc_sum  = seq_pc + acc_ext;
      end
   endgenerate

   always_comb begin
      jump_tgt = seq_pc;
      unique case (cls)
         CLS_REL:          jump_tgt = rel_tgt;
         CLS_PGJ, CLS_PGC: jump_tgt = page_tgt;
         CLS_FAR:          jump_tgt = far_tgt;
         CLS_IDXJ:         jump_tgt = ptr_sum;
         default:          jump_tgt = seq_pc;
      endcase
   end

   always_comb begin
      code_rd_addr = seq_pc;
      code_rd_en   = 1'b0;
      if (cls == CLS_TBLP) begin
         code_rd_addr = ptr_sum;
         code_rd_en   = 1'b1;
      end else if (cls == CLS_TBLC) begin
         code_rd_addr = pc_sum;
         code_rd_en   = 1'b1;
      end
   end

   assign page_miss = (want_addr[AW-1 -: HI_W] != seq_pc[AW-1 -: HI_W]);

endmodule

// File: rtl/brx_pc_reg.sv
module brx_pc_reg #(
   parameter int          AW       = 16,
   parameter logic [AW-1:0] RESET_PC = '0
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          take,
   input  logic [AW-1:0] tgt,
   input  logic [AW-1:0] seq,
   output logic [AW-1:0] pc_q
);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) pc_q <= RESET_PC;
      else        pc_q <= take ? tgt : seq;
   end

endmodule

// File: rtl/brx_addr_gen.sv
module brx_addr_gen
   import brx_pkg::*;
#(
   parameter int            AW         = 16,
   parameter int            DW         = 8,
   parameter int            PAGE_W     = 11,
   parameter bit            COND_REL   = 1'b1,
   parameter bit            SHARED_ADD = 1'b1,
   parameter logic [AW-1:0] RESET_PC   = '0
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic [AW-1:0]     instr_addr,
   input  logic [LEN_W-1:0]  instr_len,
   input  logic [DW-1:0]     opc,
   input  logic [DW-1:0]     opr1,
   input  logic [DW-1:0]     opr2,
   input  logic [DW-1:0]     acc,
   input  logic [AW-1:0]     ptr_base,
   input  logic [AW-1:0]     want_addr,
   input  logic              take,
   output logic [AW-1:0]     seq_pc,
   output logic [AW-1:0]     jump_tgt,
   output logic              is_jump,
   output logic [AW-1:0]     code_rd_addr,
   output logic              code_rd_en,
   output logic              page_miss,
   output logic [2:0]        op_class,
   output logic [AW-1:0]     pc_q
);

   generate
      if (PAGE_W != DW + 3) begin : g_bad_page
         $error("PAGE_W must equal DW + 3 (three page bits ride in the opcode)");
      end
      if (AW <= PAGE_W) begin : g_bad_aw
         $error("AW must exceed PAGE_W");
      end
      if (AW != 2 * DW) begin : g_bad_far
         $error("AW must equal two operand bytes for long targets");
      end
   endgenerate

   brx_cls_e cls;

   brx_decode #(.DW(DW), .COND_REL(COND_REL)) u_dec (
      .opc (opc),
      .cls (cls)
   );

   brx_target #(.AW(AW), .DW(DW), .PAGE_W(PAGE_W), .SHARED_ADD(SHARED_ADD)) u_tgt (
      .cls          (cls),
      .instr_addr   (instr_addr),
      .instr_len    (instr_len),
      .opc          (opc),
      .opr1         (opr1),
      .opr2         (opr2),
      .acc          (acc),
      .ptr_base     (ptr_base),
      .want_addr    (want_addr),
      .seq_pc       (seq_pc),
      .jump_tgt     (jump_tgt),
      .code_rd_addr (code_rd_addr),
      .code_rd_en   (code_rd_en),
      .page_miss    (page_miss)
   );

   brx_pc_reg #(.AW(AW), .RESET_PC(RESET_PC)) u_pc (
      .clk   (clk),
      .rst_n (rst_n),
      .take  (take),
      .tgt   (jump_tgt),
      .seq   (seq_pc),
      .pc_q  (pc_q)
   );

   assign op_class = cls;
   assign is_jump  = (cls == CLS_REL) || (cls == CLS_PGJ) || (cls == CLS_PGC) ||
                     (cls == CLS_FAR) || (cls == CLS_IDXJ);

endmodule

// File: rtl/brx_addr_gen_chk.sv
module brx_addr_gen_chk #(
   parameter int AW     = 16,
   parameter int DW     = 8,
   parameter int PAGE_W = 11
) (
   input logic          clk,
   input logic          rst_n,
   input logic [AW-1:0] instr_addr,
   input logic [1:0]    instr_len,
   input logic [DW-1:0] opr1,
   input logic [DW-1:0] opr2,
   input logic [AW-1:0] want_addr,
   input logic          take,
   input logic [AW-1:0] seq_pc,
   input logic [AW-1:0] jump_tgt,
   input logic          is_jump,
   input logic          code_rd_en,
   input logic          page_miss,
   input logic [2:0]    op_class,
   input logic [AW-1:0] pc_q
);

   logic armed;
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) armed <= 1'b0;
      else        armed <= 1'b1;
   end

   // R1
   seq_sum_chk: assert property (@(posedge clk) disable iff (!rst_n)
      seq_pc == instr_addr + AW'(instr_len));

   // R3
   page_hi_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (op_class == 3'd2 || op_class == 3'd3) |->
      jump_tgt[AW-1:PAGE_W] == seq_pc[AW-1:PAGE_W]);

   // R4
   far_tgt_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (op_class == 3'd4) |-> jump_tgt == {opr1, opr2});

   // R8
   excl_chk: assert property (@(posedge clk) disable iff (!rst_n)
      $onehot0({is_jump, code_rd_en}));

   // R8
   idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (op_class == 3'd0) |-> (jump_tgt == seq_pc && !code_rd_en && !is_jump));

   // R9
   page_miss_chk: assert property (@(posedge clk) disable iff (!rst_n)
      page_miss == (want_addr[AW-1:PAGE_W] != seq_pc[AW-1:PAGE_W]));

   // R10
   pc_load_chk: assert property (@(posedge clk) disable iff (!rst_n)
      armed |-> pc_q == ($past(take) ? $past(jump_tgt) : $past(seq_pc)));

   // R11
   class_jump_chk: assert property (@(posedge clk) disable iff (!rst_n)
      is_jump == (op_class >= 3'd1 && op_class <= 3'd5));

endmodule

bind brx_addr_gen brx_addr_gen_chk #(.AW(AW), .DW(DW), .PAGE_W(PAGE_W)) u_chk (.*);

// File: tb/brx_addr_gen_bench.sv
`timescale 1ns/1ps
module brx_addr_gen_bench;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic [15:0] instr_addr = '0;
   logic [1:0]  instr_len = '0;
   logic [7:0]  opc = '0, opr1 = '0, opr2 = '0, acc = '0;
   logic [15:0] ptr_base = '0, want_addr = '0;
   logic        take = 1'b0;
   logic [15:0] seq_pc, jump_tgt, code_rd_addr, pc_q;
   logic        is_jump, code_rd_en, page_miss;
   logic [2:0]  op_class;

   int checks = 0;
   int errors = 0;
   int exp_pc = 0;
   bit done = 1'b0;

   always #10 clk = ~clk;

   brx_addr_gen u_brx_addr_gen (.*);

   task automatic chk(string tag, int act, int exp);
      checks++;
      if (act != exp) begin
         errors++;
         $display("FAIL %s actual=%h expected=%h", tag, act, exp);
      end
   endtask

   function automatic int m_cls(int op);
      if ((op & 31) == 1)  return 2;
      if ((op & 31) == 17) return 3;
      if (op == 'h80 || op == 'h40 || op == 'h50 || op == 'h60 || op == 'h70 ||
          op == 'h10 || op == 'h20 || op == 'h30 || op == 'hD5) return 1;
      if (op >= 'hD8 && op <= 'hDF) return 1;
      if (op >= 'hB4 && op <= 'hBF) return 1;
      if (op == 'h02 || op == 'h12) return 4;
      if (op == 'h73) return 5;
      if (op == 'h93) return 6;
      if (op == 'h83) return 7;
      return 0;
   endfunction

   task automatic step(int op, int b1, int b2, int len, int addr, int a, int p,
                       int want, bit tk);
      int seq, cls, tgt, rda, rde, off, tag_n;
      string tag;
      @(negedge clk);
      chk("R10 pc_q", int'(pc_q), exp_pc);
      opc = 8'(op); opr1 = 8'(b1); opr2 = 8'(b2); instr_len = 2'(len);
      instr_addr = 16'(addr); acc = 8'(a); ptr_base = 16'(p);
      want_addr = 16'(want); take = tk;
      #3;
      seq = (addr + len) & 'hFFFF;
      cls = m_cls(op);
      tgt = seq; rda = seq; rde = 0;
      case (cls)
         1: begin
            off = (len == 3) ? b2 : b1;
            if (off >= 128) off -= 256;
            tgt = (seq + off) & 'hFFFF; tag = "R2";
         end
         2, 3: begin
            tgt = (seq & 'hF800) | (((op >> 5) & 7) << 8) | b1; tag = "R3";
         end
         4: begin tgt = (b1 << 8) | b2; tag = "R4"; end
         5: begin tgt = (p + a) & 'hFFFF; tag = "R5"; end
         6: begin rda = (p + a) & 'hFFFF; rde = 1; tag = "R6"; end
         7: begin rda = (seq + a) & 'hFFFF; rde = 1; tag = "R7"; end
         default: tag = "R8";
      endcase
      tag_n = cls;
      chk("R1 seq_pc", int'(seq_pc), seq);
      chk({tag, " jump_tgt"}, int'(jump_tgt), tgt);
      chk({tag, " code_rd_addr"}, int'(code_rd_addr), rda);
      chk({tag, " code_rd_en"}, int'(code_rd_en), rde);
      chk("R11 op_class", int'(op_class), tag_n);
      chk("R11 is_jump", int'(is_jump), (cls >= 1 && cls <= 5) ? 1 : 0);
      chk("R9 page_miss", int'(page_miss),
          ((want & 'hF800) != (seq & 'hF800)) ? 1 : 0);
      exp_pc = tk ? tgt : seq;
   endtask

   initial begin
      #(20 * 200000);
      if (!done) begin
         checks++; errors++;
         $display("FAIL watchdog actual=running expected=finished");
         $display("CHECKS %0d ERRORS %0d", checks, errors);
         $finish;
      end
   end

   initial begin
      repeat (3) @(negedge clk);
      // R10: reset state
      chk("R10 reset pc_q", int'(pc_q), 0);
      rst_n = 1'b1;
      // R2: two-byte loop onto itself, extreme offsets, 3-byte forms
      step('h80, 'hFE, 0, 2, 'h0700, 0, 0, 'h0700, 1);
      step('h80, 'h7F, 0, 2, 'h0100, 0, 0, 0, 1);
      step('h80, 'h80, 0, 2, 'h0100, 0, 0, 0, 0);
      step('hD5, 'h33, 'hFD, 3, 'h2000, 0, 0, 0, 1);
      step('hB4, 'h10, 'h05, 3, 'h2000, 0, 0, 0, 1);
      step('hDA, 'hF0, 'h77, 2, 'h3000, 0, 0, 0, 1);
      step('h40, 'h02, 0, 2, 'h0010, 0, 0, 0, 0);
      step('h20, 'h21, 'h81, 3, 'h0005, 0, 0, 0, 1);
      // R3: page from successor; R9 reach flag
      step('hF1, 'hFF, 0, 2, 'h3FFE, 0, 0, 'h47FF, 1);
      step('h11, 'h00, 0, 2, 'h5FFD, 0, 0, 'h5800, 1);
      step('hE1, 'h23, 0, 2, 'h1600, 0, 0, 'h1723, 1);
      step('hE1, 'h23, 0, 2, 'h1600, 0, 0, 'h1A23, 0);
      // R4: long forms
      step('h02, 'h07, 'h07, 3, 'h0700, 0, 0, 0, 1);
      step('h12, 'hFF, 'hFF, 3, 'h0010, 0, 0, 0, 1);
      // R5: indirect jump, including wrap
      step('h73, 0, 0, 1, 'h0200, 5, 'h4000, 0, 1);
      step('h73, 0, 0, 1, 'h0200, 2, 'hFFFF, 0, 1);
      // R6 and R7: table reads
      step('h93, 0, 0, 1, 'h0300, 5, 'h4000, 0, 0);
      step('h93, 0, 0, 1, 'h0300, 'hFF, 'hFFF0, 0, 0);
      step('h83, 0, 0, 1, 'h1002, 5, 0, 0, 0);
      // R8: neighbours that are not address forms
      step('h00, 0, 0, 1, 'h0400, 9, 'h1234, 0, 1);
      step('hB0, 'h12, 0, 2, 'h0400, 0, 0, 0, 1);
      step('hE5, 'h30, 0, 2, 'h0400, 0, 0, 0, 1);
      // R1: successor wrap
      step('h00, 0, 0, 3, 'hFFFE, 0, 0, 0, 0);
      // random stream against the model
      for (int i = 0; i < 400; i++) begin
         step(int'($urandom_range(255)), int'($urandom_range(255)),
              int'($urandom_range(255)), int'($urandom_range(3, 1)),
              int'($urandom_range(65535)), int'($urandom_range(255)),
              int'($urandom_range(65535)), int'($urandom_range(65535)),
              bit'($urandom_range(1)));
      end
      @(negedge clk);
      chk("R10 final pc_q", int'(pc_q), exp_pc);
      done = 1'b1;
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
   end

endmodule